// File: doc/BRIEF.md
# Converter Trigger and Interrupt Sequencer

This block drives a 12-bit successive-approximation converter and owns the board's single interrupt line. It takes three trigger sources: a one-cycle software write strobe, an active-low external convert input and the active-low output of a periodic timer channel. A select input enables one of them. On an accepted trigger the block pulses a start strobe to the converter. It then follows the converter's busy signal and loads the 12-bit result into a holding register. The host reads that register as a low nibble and a high byte.

Two active-low status flags record events that are pending. One flag marks a finished conversion and is released when the high data byte is read. The other marks a rising edge on a second timer channel's output and is released by a clear write. The interrupt output is the merge of both flags. External lines pass through a two-flop synchroniser before edge detection. Each falling edge counts once, however long the line then stays low.

Top module: `adc_trig_irq`

## Requirements
- R1: After reset both status bits read 1, the interrupt is low, the start strobe is low and both data outputs read 0.
- R2: The source select picks the trigger: 0 selects the software strobe, 1 the external convert input, 2 the timer channel 0 output, 3 disables all triggers. A source that is not selected causes no conversion.
- R3: With the software source selected, one write strobe produces exactly one start strobe, one cycle wide.
- R4: With the external or timer source selected, each falling edge of the synchronised input produces exactly one conversion, whatever the length of the low period.
- R5: Triggers that arrive while a conversion is in progress, from the start strobe until the result is captured, are ignored.
- R6: The result is captured when the converter's busy signal falls. The low output carries result bits 3:0 and the high output carries bits 11:4. The previous result stays visible until the next conversion completes.
- R7: Status bit 0 goes to 0 when a result is captured and returns to 1 on a strobe that reads the high data byte. A capture in the same cycle wins.
- R8: Status bit 1 goes to 0 after a low-to-high transition of the synchronised timer channel 1 output and returns to 1 on the clear write. An edge in the same cycle wins.
- R9: The interrupt is high exactly while either status bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcSel | input | 2 | Trigger source select (0 software, 1 external, 2 timer 0, 3 none) |
| swStartWr | input | 1 | Software start write strobe |
| extConvN | input | 1 | Asynchronous active-low external convert input |
| tmr0OutN | input | 1 | Asynchronous timer channel 0 output, triggers when low |
| tmr1Out | input | 1 | Asynchronous timer channel 1 output, event on rising edge |
| tmrClrWr | input | 1 | Write strobe clearing the timer event |
| rdHighStb | input | 1 | Strobe marking a host read of the high data byte |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convBusy | input | 1 | Converter busy |
| convData | input | 12 | Converter result, valid when busy falls |
| dataLow | output | 4 | Result bits 3:0 |
| dataHigh | output | 8 | Result bits 11:4 |
| statusN | output | 2 | Active-low flags: bit 0 conversion done, bit 1 timer event |
| irq | output | 1 | Merged interrupt request |

## Verification
A control state stuck outside idle shows at the ports as a start strobe that never comes back for later triggers. A double acceptance shows as a second start pulse within a few cycles of the first. A wrong capture moment shows as a data value that does not match the one the converter model produced. Flag faults show as a status bit or interrupt that disagrees with the expected value one cycle after the capture, read or clear. Flag faults on timer edges are seen four cycles after the timer line moves.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_NONE = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAITB = 2'd2,
    ST_CONV  = 2'd3
  } ctrlState_e;

  typedef struct packed {
    logic capture;
    logic tmrRise;
  } ctrlStrobes_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   srcSel,
  input  logic         swStartWr,
  input  logic         extConvN,
  input  logic         tmr0OutN,
  input  logic         tmr1Out,
  input  logic         convBusy,
  output logic         convStart,
  output ctrlStrobes_t strb
);
  localparam int NUM_LINES = 3;
  localparam logic [NUM_LINES-1:0] LINE_RST = 3'b011;

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncLines;
  logic [NUM_LINES-1:0] prevLines;
  logic extFall, tmrFall, t1Rise, trigReq;
  ctrlState_e state, stateNext;

  assign rawLines = {tmr1Out, tmr0OutN, extConvN};

  for (genvar g = 0; g < NUM_LINES; g++) begin : gSync
    adc_trig_sync #(
      .STAGES(SYNC_STAGES),
      .RESET_VAL(LINE_RST[g])
    ) u_sync (
      .clk(clk),
      .rst_n(rst_n),
      .asyncIn(rawLines[g]),
      .syncOut(syncLines[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLines <= LINE_RST;
    else        prevLines <= syncLines;
  end

  assign extFall = prevLines[0] & ~syncLines[0];
  assign tmrFall = prevLines[1] & ~syncLines[1];
  assign t1Rise  = ~prevLines[2] & syncLines[2];

  always_comb begin
    case (srcSel_e'(srcSel))
      SRC_SW:  trigReq = swStartWr;
      SRC_EXT: trigReq = extFall;
      SRC_TMR: trigReq = tmrFall;
      default: trigReq = 1'b0;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (trigReq) stateNext = ST_START;
      ST_START: stateNext = ST_WAITB;
      ST_WAITB: if (convBusy) stateNext = ST_CONV;
      ST_CONV:  if (!convBusy) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign convStart    = (state == ST_START);
  assign strb.capture = (state == ST_CONV) && !convBusy;
  assign strb.tmrRise = t1Rise;

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |=> !convStart);

  assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    convBusy |-> !convStart);

  assert_capture_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> !strb.capture);
endmodule

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LOW_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        strb,
  input  logic [DATA_W-1:0]   convData,
  input  logic                rdHighStb,
  input  logic                tmrClrWr,
  output logic [LOW_W-1:0]    dataLow,
  output logic [DATA_W-LOW_W-1:0] dataHigh,
  output logic [1:0]          statusN,
  output logic                irq
);
  logic [DATA_W-1:0] holdReg;
  logic adcReadyN, tmrReadyN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            holdReg <= '0;
    else if (strb.capture) holdReg <= convData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            adcReadyN <= 1'b1;
    else if (strb.capture) adcReadyN <= 1'b0;
    else if (rdHighStb)    adcReadyN <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tmrReadyN <= 1'b1;
    else if (strb.tmrRise) tmrReadyN <= 1'b0;
    else if (tmrClrWr)     tmrReadyN <= 1'b1;
  end

  assign dataLow  = holdReg[LOW_W-1:0];
  assign dataHigh = holdReg[DATA_W-1:LOW_W];
  assign statusN  = {tmrReadyN, adcReadyN};
  assign irq      = ~(adcReadyN & tmrReadyN);

  assert_capture_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> !statusN[0] && irq);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdHighStb && !strb.capture) |=> statusN[0]);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable({dataHigh, dataLow}));

  assert_tmr_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.tmrRise |=> !statusN[1] && irq);

  assert_tmr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmrClrWr && !strb.tmrRise) |=> statusN[1]);
endmodule

// File: rtl/adc_trig_irq.sv
module adc_trig_irq
  import adc_trig_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LOW_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              srcSel,
  input  logic                    swStartWr,
  input  logic                    extConvN,
  input  logic                    tmr0OutN,
  input  logic                    tmr1Out,
  input  logic                    tmrClrWr,
  input  logic                    rdHighStb,
  output logic                    convStart,
  input  logic                    convBusy,
  input  logic [DATA_W-1:0]       convData,
  output logic [LOW_W-1:0]        dataLow,
  output logic [DATA_W-LOW_W-1:0] dataHigh,
  output logic [1:0]              statusN,
  output logic                    irq
);
  ctrlStrobes_t strb;

  adc_trig_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .srcSel(srcSel), .swStartWr(swStartWr),
    .extConvN(extConvN), .tmr0OutN(tmr0OutN), .tmr1Out(tmr1Out),
    .convBusy(convBusy), .convStart(convStart), .strb(strb)
  );

  adc_trig_dp #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .convData(convData),
    .rdHighStb(rdHighStb), .tmrClrWr(tmrClrWr), .dataLow(dataLow),
    .dataHigh(dataHigh), .statusN(statusN), .irq(irq)
  );
endmodule

// File: tb/adc_trig_irq_tb.sv
module adc_trig_irq_tb;
  localparam int CONV_CYC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] srcSel = 2'd0;
  logic swStartWr = 1'b0, extConvN = 1'b1, tmr0OutN = 1'b1, tmr1Out = 1'b0;
  logic tmrClrWr = 1'b0, rdHighStb = 1'b0;
  logic convStart, convBusy, irq;
  logic [11:0] convData;
  logic [3:0] dataLow;
  logic [7:0] dataHigh;
  logic [1:0] statusN;

  logic [11:0] nextData = 12'h000;
  int busyCnt;
  int startCount = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_trig_irq u_dut (
    .clk(clk), .rst_n(rst_n), .srcSel(srcSel), .swStartWr(swStartWr),
    .extConvN(extConvN), .tmr0OutN(tmr0OutN), .tmr1Out(tmr1Out),
    .tmrClrWr(tmrClrWr), .rdHighStb(rdHighStb), .convStart(convStart),
    .convBusy(convBusy), .convData(convData), .dataLow(dataLow),
    .dataHigh(dataHigh), .statusN(statusN), .irq(irq)
  );

  // converter model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convBusy <= 1'b0; convData <= 12'h000; busyCnt <= 0;
    end else if (convStart) begin
      convBusy <= 1'b1; busyCnt <= CONV_CYC;
    end else if (convBusy) begin
      if (busyCnt == 1) begin
        convBusy <= 1'b0; convData <= nextData;
      end
      busyCnt <= busyCnt - 1;
    end
  end

  always @(posedge clk) if (rst_n && convStart) startCount <= startCount + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic pulse_sw();
    @(negedge clk) swStartWr = 1'b1;
    @(negedge clk) swStartWr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk) rdHighStb = 1'b1;
    @(negedge clk) rdHighStb = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) tmrClrWr = 1'b1;
    @(negedge clk) tmrClrWr = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (statusN[0] != 1'b0 && n < 100) begin
      @(negedge clk); n++;
    end
    check(req, int'(statusN[0]), 0);
  endtask

  task automatic check_data(input string req, input logic [11:0] v);
    check(req, int'({dataHigh, dataLow}), int'(v));
    check(req, int'(dataLow), int'(v[3:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(statusN), 3);
    check("R1", int'(irq), 0);
    check("R1", int'(convStart), 0);
    check("R1", int'({dataHigh, dataLow}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 single software start gives one start pulse
    s0 = startCount;
    nextData = 12'hA5C;
    pulse_sw();
    wait_ready("R7");
    check("R3", startCount - s0, 1);
    check_data("R6", 12'hA5C);
    check("R9", int'(irq), 1);
    pulse_rd();
    check("R7", int'(statusN[0]), 1);
    check("R9", int'(irq), 0);

    // R6 sweep of result values through the split outputs
    for (int v = 0; v < 4096; v += 13) begin
      nextData = 12'(v);
      pulse_sw();
      wait_ready("R7");
      check_data("R6", 12'(v));
      pulse_rd();
      check("R7", int'(statusN[0]), 1);
    end

    // R6 previous result held during a new conversion, unread result overwritten
    nextData = 12'h3C1;
    pulse_sw();
    wait_ready("R7");
    nextData = 12'h7E2;
    pulse_sw();
    repeat (3) @(negedge clk);
    check_data("R6", 12'h3C1);
    repeat (CONV_CYC + 4) @(negedge clk);
    check_data("R6", 12'h7E2);
    pulse_rd();

    // R5 triggers during conversion ignored
    s0 = startCount;
    pulse_sw();
    repeat (2) @(negedge clk);
    pulse_sw();
    repeat (2) @(negedge clk);
    pulse_sw();
    wait_ready("R5");
    repeat (10) @(negedge clk);
    check("R5", startCount - s0, 1);
    pulse_rd();

    // R2/R4 external source; software strobe has no effect
    srcSel = 2'd1;
    s0 = startCount;
    pulse_sw();
    repeat (20) @(negedge clk);
    check("R2", startCount - s0, 0);
    check("R2", int'(statusN[0]), 1);
    nextData = 12'h0F3;
    @(negedge clk) extConvN = 1'b0;
    repeat (40) @(negedge clk);
    extConvN = 1'b1;
    wait_ready("R4");
    repeat (5) @(negedge clk);
    check("R4", startCount - s0, 1);
    check_data("R4", 12'h0F3);
    pulse_rd();
    // timer 0 line ignored in external mode
    s0 = startCount;
    @(negedge clk) tmr0OutN = 1'b0;
    repeat (8) @(negedge clk);
    tmr0OutN = 1'b1;
    repeat (20) @(negedge clk);
    check("R2", startCount - s0, 0);

    // R4 timer 0 source
    srcSel = 2'd2;
    s0 = startCount;
    nextData = 12'hD18;
    @(negedge clk) tmr0OutN = 1'b0;
    repeat (4) @(negedge clk);
    tmr0OutN = 1'b1;
    wait_ready("R4");
    repeat (5) @(negedge clk);
    check("R4", startCount - s0, 1);
    check_data("R4", 12'hD18);
    pulse_rd();

    // R2 all sources disabled
    srcSel = 2'd3;
    s0 = startCount;
    pulse_sw();
    @(negedge clk) begin extConvN = 1'b0; tmr0OutN = 1'b0; end
    repeat (6) @(negedge clk);
    extConvN = 1'b1; tmr0OutN = 1'b1;
    repeat (20) @(negedge clk);
    check("R2", startCount - s0, 0);
    check("R2", int'(statusN[0]), 1);

    // R8 timer 1 event flag and clear
    @(negedge clk) tmr1Out = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", int'(statusN[1]), 0);
    check("R9", int'(irq), 1);
    @(negedge clk) tmr1Out = 1'b0;
    repeat (4) @(negedge clk);
    check("R8", int'(statusN[1]), 0);
    pulse_clr();
    check("R8", int'(statusN[1]), 1);
    check("R9", int'(irq), 0);

    // R9 both pending, cleared one at a time
    srcSel = 2'd0;
    @(negedge clk) tmr1Out = 1'b1;
    repeat (4) @(negedge clk);
    nextData = 12'h555;
    pulse_sw();
    wait_ready("R7");
    check("R9", int'(statusN), 0);
    pulse_rd();
    check("R9", int'(irq), 1);
    pulse_clr();
    check("R9", int'(irq), 0);
    check("R8", int'(statusN), 3);

    report();
  end
endmodule